// File: doc/BRIEF.md
# Sampling Clock Tuning Sweep Sequencer

This block runs the sampling-clock tuning procedure of an SD/eMMC host controller. It first decides from the bus mode whether tuning is needed at all. It then programs the tap logic, probes every sampling tap twice with a tuning command and collects two result vectors. A pass vector records whether each command succeeded, and a compare vector records whether the sample-compare readout was zero. The block holds no card-bus logic and does no tap arithmetic. Each tuning command goes out over a request/acknowledge handshake, and the finished vectors go to an external selector over a second handshake.

If the selector returns a tap, the block writes that tap and turns on automatic re-tuning. If the selector rejects the sweep, the block puts the tap logic back into a neutral state. The card clock is always gated off around configuration changes. The configuration fields are kept as registers and brought out on ports, so the surrounding logic and the testbench can observe them.

Top module: `tune_sweep_seq`

## Requirements
- R1: A start with `bus_mode` outside {4 = HS200, 5 = SDR104, 6 = SDR50} finishes with `done` and `ok` = 1. It issues no tuning command, no `irq_clr` pulse and no clock gating.
- R2: Tuning setup behaves as follows:
  - one `irq_clr` pulse is issued;
  - `clk_en` goes low;
  - `tap_en` is set to 1 and `tap_cnt_cfg` to 8;
  - `dts_sel` is set to 1 and `retune_en` cleared;
  - `tap_pos` is loaded with 0x300;
  - `clk_en` returns high.
  `dts_sel` and `tap_pos` change only while `clk_en` is low.
- R3: The tap count N is taken from `hw_taps` at the end of setup. If N = 0 or 2N >= 32, the run ends with `ok` = 1 and no tuning command.
- R4: Otherwise exactly 2N tuning commands are issued. While command i is requested, `tap_sel` equals i mod N.
- R5: For command i, bit i of `pass_vec` takes `cmd_ok` and bit i of `cmp_vec` takes `cmp_zero`, both sampled with `cmd_ack`. All bits at or above 2N are 0, since both vectors are cleared on start.
- R6: `dma_out` is 0 while `cmd_req` is high. Otherwise it follows `dma_in`.
- R7: Between consecutive commands, `cmd_req` stays low for exactly WAIT_CYC cycles.
- R8: After the last command, exactly one `rvs_clr` pulse is issued, in the first cycle of `sel_req`.
- R9: When `sel_ok` is returned with `sel_ack`, the run ends with `tap_sel` = `sel_tap`, `retune_en` = 1, `ok` = 1, and `hs400_en`/`hs400_osel` unchanged from their values at start.
- R10: When the selector rejects the sweep, the block does the following before `done`, and `done` then comes with `ok` = 0:
  - gates `clk_en` off and back on;
  - clears `dts_sel`;
  - clears `hs400_en` and `hs400_osel`;
  - clears `retune_en`.
- R11: `busy` is high from the cycle after an accepted `start` through the `done` cycle. A `start` while busy is ignored.
- R12: `cmd_req` and `sel_req` stay high until their acknowledge is seen, and drop in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a tuning run (ignored while busy) |
| bus_mode | input | 3 | Current bus mode; 4, 5 and 6 need tuning |
| hs400_cfg | input | 2 | HS400 enable / output-select captured at start |
| hw_taps | input | 8 | Tap count reported by the tap logic |
| dma_in | input | 1 | DMA enable requested by the host |
| cmd_ack | input | 1 | Tuning command completed |
| cmd_ok | input | 1 | Tuning command succeeded |
| cmp_zero | input | 1 | Sample-compare readout was zero |
| sel_ack | input | 1 | Selector answered |
| sel_ok | input | 1 | Selector found a tap |
| sel_tap | input | 8 | Tap chosen by selector |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| ok | output | 1 | Run result |
| cmd_req | output | 1 | Tuning command request |
| dma_out | output | 1 | DMA enable to the data path |
| sel_req | output | 1 | Selector request |
| pass_vec | output | 32 | Command pass results |
| cmp_vec | output | 32 | Sample-compare results |
| tap_sel | output | 8 | Sampling tap in use |
| clk_en | output | 1 | Card clock enable |
| tap_en | output | 1 | Tap logic enable field |
| tap_cnt_cfg | output | 8 | Requested tap count field |
| dts_sel | output | 1 | Data-tap sampling select |
| retune_en | output | 1 | Automatic re-tuning enable |
| tap_pos | output | 12 | Tap position field |
| hs400_en | output | 1 | HS400 enable field |
| hs400_osel | output | 1 | HS400 output select field |
| irq_clr | output | 1 | Interrupt status clear pulse |
| rvs_clr | output | 1 | Re-tune error request clear pulse |

## Verification
The tests cover several cases:
- a mode that needs no tuning, which must finish without touching the tap logic;
- tap counts of 0 and 16, which must skip the sweep;
- a tap count of 15, which tests the largest vector of 30 bits;
- runs of 4 and 8 taps with different pass and compare patterns.

The sparse and alternating patterns show whether each result lands in the right bit and whether the tap wraps correctly on the second pass. An accepting selector and a rejecting one separate the apply path from the recovery sequence. A preset HS400 configuration shows that the enables are cleared only on rejection. A stray start in the middle of a run shows that the block does not restart.

// File: rtl/tune_sweep_seq.sv
module tune_sweep_seq #(
  parameter int TAPW     = 8,
  parameter int VECW     = 32,
  parameter int WAIT_CYC = 50000,
  parameter int TAP_REQ  = 8,
  parameter int POSW     = 12,
  parameter int POS_INIT = 12'h300
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      bus_mode,
  input  logic [1:0]      hs400_cfg,
  input  logic [TAPW-1:0] hw_taps,
  input  logic            dma_in,
  input  logic            cmd_ack,
  input  logic            cmd_ok,
  input  logic            cmp_zero,
  input  logic            sel_ack,
  input  logic            sel_ok,
  input  logic [TAPW-1:0] sel_tap,
  output logic            busy,
  output logic            done,
  output logic            ok,
  output logic            cmd_req,
  output logic            dma_out,
  output logic            sel_req,
  output logic [VECW-1:0] pass_vec,
  output logic [VECW-1:0] cmp_vec,
  output logic [TAPW-1:0] tap_sel,
  output logic            clk_en,
  output logic            tap_en,
  output logic [TAPW-1:0] tap_cnt_cfg,
  output logic            dts_sel,
  output logic            retune_en,
  output logic [POSW-1:0] tap_pos,
  output logic            hs400_en,
  output logic            hs400_osel,
  output logic            irq_clr,
  output logic            rvs_clr
);
  localparam int VIW = $clog2(VECW);
  localparam int WCW = $clog2(WAIT_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_INIT, S_PROBE, S_WAIT, S_SCLR, S_SEL, S_FAIL, S_DONE} st_t;

  st_t            st;
  logic [2:0]     step;
  logic [TAPW-1:0] n_taps, tap;
  logic [VIW-1:0] idx;
  logic [WCW-1:0] wcnt;

  wire tune_mode = (bus_mode == 3'd4) || (bus_mode == 3'd5) || (bus_mode == 3'd6);
  wire skip      = (hw_taps == '0) || (2 * int'(hw_taps) >= VECW);
  wire last      = (int'(idx) == 2 * int'(n_taps) - 1);

  assign busy    = (st != S_IDLE);
  assign done    = (st == S_DONE);
  assign cmd_req = (st == S_PROBE);
  assign sel_req = (st == S_SEL);
  assign dma_out = dma_in & ~cmd_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; step <= '0; n_taps <= '0; tap <= '0; idx <= '0; wcnt <= '0;
      ok <= 1'b0; pass_vec <= '0; cmp_vec <= '0; tap_sel <= '0;
      clk_en <= 1'b1; tap_en <= 1'b0; tap_cnt_cfg <= '0; dts_sel <= 1'b0;
      retune_en <= 1'b0; tap_pos <= '0; hs400_en <= 1'b0; hs400_osel <= 1'b0;
      irq_clr <= 1'b0; rvs_clr <= 1'b0;
    end else begin
      irq_clr <= 1'b0;
      rvs_clr <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          pass_vec <= '0; cmp_vec <= '0; ok <= 1'b0; step <= '0;
          hs400_en <= hs400_cfg[1]; hs400_osel <= hs400_cfg[0];
          if (tune_mode) st <= S_INIT;
          else begin ok <= 1'b1; st <= S_DONE; end
        end
        S_INIT: begin
          step <= step + 3'd1;
          case (step)
            3'd0: irq_clr <= 1'b1;
            3'd1: clk_en <= 1'b0;
            3'd2: begin tap_en <= 1'b1; tap_cnt_cfg <= TAPW'(TAP_REQ); end
            3'd3: dts_sel <= 1'b1;
            3'd4: retune_en <= 1'b0;
            3'd5: tap_pos <= POSW'(POS_INIT);
            3'd6: clk_en <= 1'b1;
            default: begin
              n_taps <= hw_taps; idx <= '0; tap <= '0; tap_sel <= '0;
              if (skip) begin ok <= 1'b1; st <= S_DONE; end
              else st <= S_PROBE;
            end
          endcase
        end
        S_PROBE: if (cmd_ack) begin
          pass_vec[idx] <= cmd_ok;
          cmp_vec[idx]  <= cmp_zero;
          idx <= idx + 1'b1;
          tap <= (tap == n_taps - 1'b1) ? '0 : tap + 1'b1;
          wcnt <= '0;
          st <= last ? S_SCLR : S_WAIT;
        end
        S_WAIT: begin
          if (wcnt == WCW'(WAIT_CYC - 1)) begin st <= S_PROBE; tap_sel <= tap; end
          else wcnt <= wcnt + 1'b1;
        end
        S_SCLR: begin rvs_clr <= 1'b1; st <= S_SEL; end
        S_SEL: if (sel_ack) begin
          if (sel_ok) begin
            tap_sel <= sel_tap; retune_en <= 1'b1; ok <= 1'b1; st <= S_DONE;
          end else begin
            step <= '0; st <= S_FAIL;
          end
        end
        S_FAIL: begin
          step <= step + 3'd1;
          case (step)
            3'd0: clk_en <= 1'b0;
            3'd1: dts_sel <= 1'b0;
            3'd2: begin hs400_en <= 1'b0; hs400_osel <= 1'b0; end
            3'd3: clk_en <= 1'b1;
            default: begin retune_en <= 1'b0; ok <= 1'b0; st <= S_DONE; end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tune_sweep_seq_chk.sv
module tune_sweep_seq_chk #(parameter int POSW = 12) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            ok,
  input logic            cmd_req,
  input logic            cmd_ack,
  input logic            sel_req,
  input logic            sel_ack,
  input logic            dma_out,
  input logic            clk_en,
  input logic            dts_sel,
  input logic [POSW-1:0] tap_pos,
  input logic            retune_en,
  input logic            hs400_en,
  input logic            hs400_osel,
  input logic            rvs_clr
);
  p_pos_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tap_pos) |-> !clk_en);
  p_dts_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dts_sel) |-> !clk_en);
  p_dma_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> !dma_out);
  p_rvs_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rvs_clr |-> sel_req);
  p_fail_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ok) |-> (!retune_en && !dts_sel && !hs400_en && !hs400_osel && clk_en));
  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  p_cmd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_ack) |=> cmd_req);
  p_sel_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_req && !sel_ack) |=> sel_req);
endmodule

bind tune_sweep_seq tune_sweep_seq_chk #(.POSW(POSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .ok(ok),
  .cmd_req(cmd_req), .cmd_ack(cmd_ack), .sel_req(sel_req), .sel_ack(sel_ack),
  .dma_out(dma_out), .clk_en(clk_en), .dts_sel(dts_sel), .tap_pos(tap_pos),
  .retune_en(retune_en), .hs400_en(hs400_en), .hs400_osel(hs400_osel),
  .rvs_clr(rvs_clr)
);

// File: tb/tune_sweep_seq_test.sv
module tune_sweep_seq_test;
  localparam int WAIT_CYC = 5;

  logic clk = 0, rst_n = 0, start = 0, dma_in = 0;
  logic [2:0] bus_mode = 0;
  logic [1:0] hs400_cfg = 0;
  logic [7:0] hw_taps = 0, sel_tap = 0;
  logic cmd_ack = 0, cmd_ok = 0, cmp_zero = 0, sel_ack = 0, sel_ok = 0;
  logic busy, done, ok, cmd_req, dma_out, sel_req, clk_en, tap_en, dts_sel;
  logic retune_en, hs400_en, hs400_osel, irq_clr, rvs_clr;
  logic [31:0] pass_vec, cmp_vec;
  logic [7:0] tap_sel, tap_cnt_cfg;
  logic [11:0] tap_pos;

  int n_cmp = 0, n_bad = 0;
  bit m_busy = 0;

  always #10 clk = ~clk;

  tune_sweep_seq #(.WAIT_CYC(WAIT_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_mode(bus_mode), .hs400_cfg(hs400_cfg),
    .hw_taps(hw_taps), .dma_in(dma_in), .cmd_ack(cmd_ack), .cmd_ok(cmd_ok),
    .cmp_zero(cmp_zero), .sel_ack(sel_ack), .sel_ok(sel_ok), .sel_tap(sel_tap),
    .busy(busy), .done(done), .ok(ok), .cmd_req(cmd_req), .dma_out(dma_out),
    .sel_req(sel_req), .pass_vec(pass_vec), .cmp_vec(cmp_vec), .tap_sel(tap_sel),
    .clk_en(clk_en), .tap_en(tap_en), .tap_cnt_cfg(tap_cnt_cfg), .dts_sel(dts_sel),
    .retune_en(retune_en), .tap_pos(tap_pos), .hs400_en(hs400_en),
    .hs400_osel(hs400_osel), .irq_clr(irq_clr), .rvs_clr(rvs_clr));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one tuning run; the bench acts as card-side responder and selector
  task automatic run(input logic [2:0] mode, input logic [7:0] n, input logic [31:0] ppat,
                     input logic [31:0] cpat, input bit s_ok, input logic [7:0] s_tap,
                     input logic [1:0] h4, input bit poke);
    int probes = 0, age = 0, sage = 0, gap = 0, irqs = 0, rvs = 0, gates = 0, cyc = 0;
    bit prev_clk = 1, tuned, swept;
    logic [63:0] mask;
    tuned = (mode == 4) || (mode == 5) || (mode == 6);
    swept = tuned && n != 0 && 2 * n < 32;
    mask  = swept ? ((64'd1 << (2 * n)) - 1) : 64'd0;
    @(negedge clk);
    bus_mode = mode; hw_taps = n; hs400_cfg = h4; start = 1; dma_in = 1;
    @(negedge clk);
    start = 0; m_busy = 1;
    chk("R11 busy after start", busy, 1);
    forever begin
      cyc++;
      if (poke && cyc == 3) start = 1;
      if (poke && cyc == 4) start = 0;
      cmd_ack = 0; sel_ack = 0;
      chk("R6 dma follows request", dma_out, dma_in & ~cmd_req);
      chk("R11 busy model", busy, m_busy);
      if (irq_clr) irqs++;
      if (prev_clk && !clk_en) gates++;
      prev_clk = clk_en;
      if (rvs_clr) rvs++;
      if (cmd_req) begin
        if (age == 0) begin
          chk("R4 tap during probe", tap_sel, probes % n);
          if (probes > 0) chk("R7 wait gap", gap, WAIT_CYC);
          gap = 0;
        end
        age++;
        if (age == 3) begin
          cmd_ack = 1; cmd_ok = ppat[probes]; cmp_zero = cpat[probes];
          probes++; age = 0;
        end
      end else if (probes > 0) gap++;
      if (sel_req) begin
        if (sage == 0) begin
          chk("R8 one rvs clear at selection", rvs, 1);
          chk("R4 probe count", probes, 2 * n);
          chk("R5 pass vector", pass_vec, ppat & mask);
          chk("R5 compare vector", cmp_vec, cpat & mask);
          chk("R2 tap enable", tap_en, 1);
          chk("R2 tap count field", tap_cnt_cfg, 8);
          chk("R2 tap position", tap_pos, 12'h300);
          chk("R2 data tap select", dts_sel, 1);
          chk("R2 clock restored", clk_en, 1);
          chk("R2 retune off", retune_en, 0);
        end
        sage++;
        if (sage == 2) begin sel_ack = 1; sel_ok = s_ok; sel_tap = s_tap; sage = 0; end
      end
      if (done) begin
        chk("R11 irq clear once per run", irqs, tuned ? 1 : 0);
        if (!tuned) begin
          chk("R1 ok without tuning", ok, 1);
          chk("R1 no command", probes, 0);
          chk("R1 no gating", gates, 0);
        end else if (!swept) begin
          chk("R3 ok on skip", ok, 1);
          chk("R3 no command", probes, 0);
          chk("R2 one gating", gates, 1);
        end else if (s_ok) begin
          chk("R9 ok", ok, 1);
          chk("R9 tap applied", tap_sel, s_tap);
          chk("R9 retune on", retune_en, 1);
          chk("R9 hs400 kept", {hs400_en, hs400_osel}, h4);
        end else begin
          chk("R10 ok low", ok, 0);
          chk("R10 second gating", gates, 2);
          chk("R10 dts cleared", dts_sel, 0);
          chk("R10 hs400 cleared", {hs400_en, hs400_osel}, 0);
          chk("R10 retune off", retune_en, 0);
          chk("R10 clock on", clk_en, 1);
        end
        m_busy = 0;
        @(negedge clk);
        chk("R11 idle after done", busy, 0);
        break;
      end
      if (cyc > 20000) begin
        n_bad++; $display("FAIL R11 run hung actual=busy expected=done");
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset idle", busy, 0);
    chk("R10 reset clock on", clk_en, 1);
    chk("R12 reset no request", {cmd_req, sel_req}, 0);
    run(3'd1, 8'd4, 32'hFF, 32'hFF, 1, 8'd1, 2'b00, 0);
    run(3'd4, 8'd4, 32'hFF, 32'hF3, 1, 8'd2, 2'b10, 1);
    run(3'd5, 8'd8, 32'hA5A5, 32'h0F0F, 0, 8'd0, 2'b11, 0);
    run(3'd6, 8'd0, 32'h0, 32'h0, 1, 8'd0, 2'b00, 0);
    run(3'd4, 8'd16, 32'h0, 32'h0, 1, 8'd0, 2'b00, 0);
    run(3'd6, 8'd15, 32'h3FFF_FFFE, 32'h2000_0001, 1, 8'd14, 2'b01, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule